// File: doc/BRIEF.md
# Endpoint Interrupt Collector with Indexed Bank

This block gathers the interrupt events of a six-endpoint USB controller and shows them to software as byte-wide registers on a simple register bus. Each endpoint has a transmit event flag; endpoints 1 to 5 also have a receive event flag. Eight bus-level events are kept as well. Every flag group has its own enable register. A single interrupt line is raised whenever any flag is pending together with its enable bit.

Flags are sticky. A one-cycle event pulse sets a flag, and a read of the flag register returns the value and clears it. An event that lands in the same cycle as the clearing read is kept for the next read.

An endpoint index register selects one endpoint. A banked register at a fixed address then shows that endpoint's flags and enables, and a write to it changes that endpoint's enables. The interrupt line is driven by a two-state machine. In state `IRQ_QUIET` the line is low. The transition QUIET→RAISED is taken on any pending enabled flag. The transition RAISED→QUIET is taken when none remains. Reads take effect at the clock edge of the read cycle, and `bus_rdata` holds the result until the next read.

Top module: `ep_irq_ctrl`

## Requirements
- R1: After reset all flags are 0, the index is 0, the interrupt line is low, and all enables are 0 except transmit enable bit 0 (endpoint 0), which is 1.
- R2: The register addresses are: 0 transmit flags, 1 receive flags, 2 bus flags, 3 transmit enable, 4 receive enable, 5 bus enable, 6 index, 7 banked endpoint register. Addresses 8 to 15 read 0. Narrow registers read with zeros in their unused upper bits.
- R3: In the transmit flag register, bit n is set by `tx_evt[n]`, for endpoints 0 to 5.
- R4: In the receive flag register, bits 1 to 5 are set by `rx_evt[1..5]`. Bit 0 always reads 0 and `rx_evt[0]` has no effect. Receive enable bit 0 can be written neither directly nor through the bank, and always reads 0.
- R5: The bus flag bits are, from bit 7 down to bit 0: VBUS error, session request, disconnect, connect, start of frame, reset, resume, suspend. Bit n is set by `bus_evt[n]`.
- R6: A flag stays set after its pulse until its flag register is read. That read returns the set value and clears the flag, so the next read returns 0.
- R7: If an event arrives in the same cycle as a clearing read of its register, the read returns the prior value and the flag is set afterwards.
- R8: `irq` is high in the cycle after a cycle in which some flag AND its enable is 1, and low in the cycle after a cycle in which there is none.
- R9: A write of 0 to 5 to the index register is stored. A write of a value greater than 5 is ignored and the old index is kept.
- R10: The banked register reads {4'b0, receive enable, transmit enable, receive flag, transmit flag} of the indexed endpoint. Reading it clears nothing. A write to it sets that endpoint's transmit enable from data bit 2 and its receive enable from data bit 3.
- R11: The enable registers read back the value last written, with receive enable bit 0 forced to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 4 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (clears flag registers) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, updated at the edge of the read cycle |
| tx_evt | input | 6 | Transmit event pulses, one per endpoint |
| rx_evt | input | 6 | Receive event pulses (bit 0 unused) |
| bus_evt | input | 8 | Bus-level event pulses |
| irq | output | 1 | Combined interrupt request |

## Verification
Each flag group is swept one bit at a time, with each single-bit enable of the bus group crossed against each single-bit event. This separates a wrong bit position from a wrong enable gating, and shows the missing receive endpoint 0. Multi-bit event patterns check that bits are combined correctly. Reading each flag register twice separates read-clear from a flag that is sticky or never set. An event placed on the very cycle of a clearing read shows whether that event is lost. The index sweep runs past 5 to tell ignored writes from stored ones. The banked sweep visits every endpoint and reads twice, to show that the bank steers correctly and never clears.

// File: rtl/uic_pkg.sv
package uic_pkg;
    localparam int REG_W  = 8;
    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] A_TX_FLAG = 4'd0;
    localparam logic [ADDR_W-1:0] A_RX_FLAG = 4'd1;
    localparam logic [ADDR_W-1:0] A_BUS_FLAG = 4'd2;
    localparam logic [ADDR_W-1:0] A_TX_EN   = 4'd3;
    localparam logic [ADDR_W-1:0] A_RX_EN   = 4'd4;
    localparam logic [ADDR_W-1:0] A_BUS_EN  = 4'd5;
    localparam logic [ADDR_W-1:0] A_INDEX   = 4'd6;
    localparam logic [ADDR_W-1:0] A_BANK    = 4'd7;

    typedef enum logic {
        IRQ_QUIET  = 1'b0,
        IRQ_RAISED = 1'b1
    } irq_state_t;
endpackage

// File: rtl/uic_flag_bank.sv
module uic_flag_bank #(
    parameter int          W    = 6,
    parameter logic [W-1:0] KEEP = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic         clr_i,
    output logic [W-1:0] flags_o
);
    logic [W-1:0] set_m;
    logic [W-1:0] flags_q;

    assign set_m = set_i & KEEP;

    generate
        for (genvar i = 0; i < W; i++) begin : g_bit
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    flags_q[i] <= 1'b0;
                else if (set_m[i])
                    flags_q[i] <= 1'b1;
                else if (clr_i)
                    flags_q[i] <= 1'b0;
            end
        end
    endgenerate

    assign flags_o = flags_q;

    AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (set_m != '0) |=> ((flags_o & $past(set_m)) == $past(set_m))); // R7
    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> ((flags_o & $past(flags_o)) == $past(flags_o))); // R6
    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && set_m == '0) |=> (flags_o == '0)); // R6
endmodule

// File: rtl/uic_index_reg.sv
module uic_index_reg #(
    parameter int NUM_EP = 6,
    parameter int DATA_W = 8,
    localparam int IDX_W = $clog2(NUM_EP)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [IDX_W-1:0]  idx_o
);
    localparam logic [DATA_W-1:0] MAX_IDX = DATA_W'(NUM_EP - 1);

    logic accept;
    assign accept = wr_i && (wdata_i <= MAX_IDX);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            idx_o <= '0;
        else if (accept)
            idx_o <= wdata_i[IDX_W-1:0];
    end

    AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (DATA_W'(idx_o) <= MAX_IDX)); // R9
    AST_IDX_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && wdata_i > MAX_IDX) |=> $stable(idx_o)); // R9
endmodule

// File: rtl/uic_irq_fsm.sv
module uic_irq_fsm
    import uic_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pending_i,
    output logic irq_o
);
    irq_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IRQ_QUIET;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        irq_o   = 1'b0;
        unique case (state_q)
            IRQ_QUIET: begin
                irq_o = 1'b0;
                if (pending_i) state_d = IRQ_RAISED;
            end
            IRQ_RAISED: begin
                irq_o = 1'b1;
                if (!pending_i) state_d = IRQ_QUIET;
            end
            default: state_d = IRQ_QUIET;
        endcase
    end

    AST_IRQ_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        pending_i |=> irq_o); // R8
    AST_IRQ_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !pending_i |=> !irq_o); // R8
endmodule

// File: rtl/ep_irq_ctrl.sv
module ep_irq_ctrl
    import uic_pkg::*;
#(
    parameter int NUM_EP   = 6,
    parameter int NUM_BEVT = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [REG_W-1:0]    bus_wdata,
    output logic [REG_W-1:0]    bus_rdata,
    input  logic [NUM_EP-1:0]   tx_evt,
    input  logic [NUM_EP-1:0]   rx_evt,
    input  logic [NUM_BEVT-1:0] bus_evt,
    output logic                irq
);
    localparam int IDX_W = $clog2(NUM_EP);
    localparam int EP_PAD = REG_W - NUM_EP;
    localparam int BEV_PAD = REG_W - NUM_BEVT;
    localparam logic [NUM_EP-1:0] RX_KEEP = {{(NUM_EP-1){1'b1}}, 1'b0};
    localparam logic [NUM_EP-1:0] TX_EN_RST = NUM_EP'(1);

    logic [NUM_EP-1:0]   tx_flags, rx_flags;
    logic [NUM_BEVT-1:0] bus_flags;
    logic [NUM_EP-1:0]   tx_en_q, rx_en_q;
    logic [NUM_BEVT-1:0] bus_en_q;
    logic [IDX_W-1:0]    idx;
    logic [REG_W-1:0]    rd_mux, rdata_q;
    logic                clr_tx, clr_rx, clr_bus, pending;
    logic                wr_tx_en, wr_rx_en, wr_bus_en, wr_idx, wr_bank;

    assign clr_tx    = bus_rd && (bus_addr == A_TX_FLAG);
    assign clr_rx    = bus_rd && (bus_addr == A_RX_FLAG);
    assign clr_bus   = bus_rd && (bus_addr == A_BUS_FLAG);
    assign wr_tx_en  = bus_wr && (bus_addr == A_TX_EN);
    assign wr_rx_en  = bus_wr && (bus_addr == A_RX_EN);
    assign wr_bus_en = bus_wr && (bus_addr == A_BUS_EN);
    assign wr_idx    = bus_wr && (bus_addr == A_INDEX);
    assign wr_bank   = bus_wr && (bus_addr == A_BANK);

    uic_flag_bank #(.W(NUM_EP), .KEEP('1)) u_tx_flags (
        .clk(clk), .rst_n(rst_n), .set_i(tx_evt), .clr_i(clr_tx), .flags_o(tx_flags));

    uic_flag_bank #(.W(NUM_EP), .KEEP(RX_KEEP)) u_rx_flags (
        .clk(clk), .rst_n(rst_n), .set_i(rx_evt), .clr_i(clr_rx), .flags_o(rx_flags));

    uic_flag_bank #(.W(NUM_BEVT), .KEEP('1)) u_bus_flags (
        .clk(clk), .rst_n(rst_n), .set_i(bus_evt), .clr_i(clr_bus), .flags_o(bus_flags));

    uic_index_reg #(.NUM_EP(NUM_EP), .DATA_W(REG_W)) u_index (
        .clk(clk), .rst_n(rst_n), .wr_i(wr_idx), .wdata_i(bus_wdata), .idx_o(idx));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_en_q  <= TX_EN_RST;
            rx_en_q  <= '0;
            bus_en_q <= '0;
        end else begin
            if (wr_tx_en)  tx_en_q  <= bus_wdata[NUM_EP-1:0];
            if (wr_rx_en)  rx_en_q  <= bus_wdata[NUM_EP-1:0] & RX_KEEP;
            if (wr_bus_en) bus_en_q <= bus_wdata[NUM_BEVT-1:0];
            if (wr_bank) begin
                tx_en_q[idx] <= bus_wdata[2];
                rx_en_q[idx] <= bus_wdata[3] & RX_KEEP[idx];
            end
        end
    end

    always_comb begin
        rd_mux = '0;
        unique case (bus_addr)
            A_TX_FLAG:  rd_mux = {{EP_PAD{1'b0}}, tx_flags};
            A_RX_FLAG:  rd_mux = {{EP_PAD{1'b0}}, rx_flags};
            A_BUS_FLAG: rd_mux = {{BEV_PAD{1'b0}}, bus_flags};
            A_TX_EN:    rd_mux = {{EP_PAD{1'b0}}, tx_en_q};
            A_RX_EN:    rd_mux = {{EP_PAD{1'b0}}, rx_en_q};
            A_BUS_EN:   rd_mux = {{BEV_PAD{1'b0}}, bus_en_q};
            A_INDEX:    rd_mux = {{(REG_W-IDX_W){1'b0}}, idx};
            A_BANK:     rd_mux = {4'b0000, rx_en_q[idx], tx_en_q[idx],
                                  rx_flags[idx], tx_flags[idx]};
            default:    rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rdata_q <= '0;
        else if (bus_rd) rdata_q <= rd_mux;
    end

    assign bus_rdata = rdata_q;
    assign pending = |(tx_flags & tx_en_q) | |(rx_flags & rx_en_q) | |(bus_flags & bus_en_q);

    uic_irq_fsm u_irq (.clk(clk), .rst_n(rst_n), .pending_i(pending), .irq_o(irq));

    AST_RX_EN0_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_rx_en || wr_bank) |=> !rx_en_q[0]); // R4
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata)); // R2
    AST_BANK_NOCLR: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == A_BANK) |=>
        ((tx_flags & $past(tx_flags)) == $past(tx_flags))); // R10
endmodule

// File: tb/tb_ep_irq_ctrl.sv
module tb_ep_irq_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] bus_addr = '0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [5:0] tx_evt = '0, rx_evt = '0;
    logic [7:0] bus_evt = '0;
    logic       irq;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    ep_irq_ctrl dut (.*);

    task automatic chk(input int act, input int exp, input string req);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk); bus_addr = a; bus_rd = 1'b1;
        @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] v);
        @(negedge clk); bus_addr = a; bus_wdata = v; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic pulse(input logic [5:0] t, input logic [5:0] r, input logic [7:0] b);
        @(negedge clk); tx_evt = t; rx_evt = r; bus_evt = b;
        @(negedge clk); tx_evt = '0; rx_evt = '0; bus_evt = '0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] d;
        int exp_idx;
        int exp_ten;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state, R2 map
        @(negedge clk); chk(irq, 0, "R1 irq");
        rd(4'd0, d); chk(d, 0, "R1 tx flags");
        rd(4'd1, d); chk(d, 0, "R1 rx flags");
        rd(4'd2, d); chk(d, 0, "R1 bus flags");
        rd(4'd3, d); chk(d, 8'h01, "R1 tx enable");
        rd(4'd4, d); chk(d, 0, "R1 rx enable");
        rd(4'd5, d); chk(d, 0, "R1 bus enable");
        rd(4'd6, d); chk(d, 0, "R1 index");
        for (int a = 8; a < 16; a++) begin
            rd(4'(a), d); chk(d, 0, "R2 unmapped");
        end

        // R3 transmit sweep, R6 read-clear, R8 with reset enable
        for (int i = 0; i < 6; i++) begin
            pulse(6'(1 << i), '0, '0);
            @(negedge clk); chk(irq, (i == 0) ? 1 : 0, "R8 tx irq");
            rd(4'd0, d); chk(d, 1 << i, "R3 tx flag bit");
            rd(4'd0, d); chk(d, 0, "R6 tx cleared");
            @(negedge clk); chk(irq, 0, "R8 irq drop");
        end

        // R4 receive sweep, R11 readback
        wr(4'd4, 8'h3F);
        rd(4'd4, d); chk(d, 8'h3E, "R4 R11 rx enable bit0");
        for (int i = 0; i < 6; i++) begin
            pulse('0, 6'(1 << i), '0);
            @(negedge clk); chk(irq, (i == 0) ? 0 : 1, "R8 rx irq");
            rd(4'd1, d); chk(d, (i == 0) ? 0 : (1 << i), "R4 rx flag bit");
            rd(4'd1, d); chk(d, 0, "R6 rx cleared");
        end
        wr(4'd4, 8'h00);

        // multi-bit patterns
        pulse(6'h2A, 6'h15, 8'hA5);
        rd(4'd0, d); chk(d, 8'h2A, "R3 tx pattern");
        rd(4'd1, d); chk(d, 8'h14, "R4 rx pattern");
        rd(4'd2, d); chk(d, 8'hA5, "R5 bus pattern");
        @(negedge clk); chk(irq, 0, "R8 no enabled flag");

        // R5 bus event sweep crossed with each single enable
        for (int b = 0; b < 8; b++) begin
            wr(4'd5, 8'(1 << b));
            rd(4'd5, d); chk(d, 1 << b, "R11 bus enable");
            for (int e = 0; e < 8; e++) begin
                pulse('0, '0, 8'(1 << e));
                @(negedge clk); chk(irq, (e == b) ? 1 : 0, "R5 R8 bus irq");
                rd(4'd2, d); chk(d, 1 << e, "R5 bus flag bit");
                @(negedge clk); chk(irq, 0, "R8 bus irq drop");
            end
        end
        wr(4'd5, 8'h00);

        // R7 event concurrent with clearing read
        @(negedge clk); bus_addr = 4'd0; bus_rd = 1'b1; tx_evt = 6'h08;
        @(negedge clk); bus_rd = 1'b0; tx_evt = '0; d = bus_rdata;
        chk(d, 0, "R7 read returns prior");
        rd(4'd0, d); chk(d, 8'h08, "R7 flag kept");
        rd(4'd0, d); chk(d, 0, "R7 then cleared");

        // R9 index sweep
        exp_idx = 0;
        for (int v = 0; v < 10; v++) begin
            int vv;
            vv = (v * 7) % 10;
            wr(4'd6, 8'(vv));
            if (vv <= 5) exp_idx = vv;
            rd(4'd6, d); chk(d, exp_idx, "R9 index");
        end
        wr(4'd6, 8'hFF);
        rd(4'd6, d); chk(d, exp_idx, "R9 index 0xFF ignored");

        // R10 banked access per endpoint
        wr(4'd3, 8'h00);
        exp_ten = 0;
        for (int ep = 0; ep < 6; ep++) begin
            int eb;
            wr(4'd6, 8'(ep));
            wr(4'd7, 8'h0C);
            exp_ten = exp_ten | (1 << ep);
            rd(4'd3, d); chk(d, exp_ten, "R10 bank tx enable");
            rd(4'd4, d); chk(d, exp_ten & 8'h3E, "R10 R4 bank rx enable");
            pulse(6'(1 << ep), 6'(1 << ep), '0);
            eb = 5 | ((ep != 0) ? 10 : 0);
            rd(4'd7, d); chk(d, eb, "R10 bank view");
            rd(4'd7, d); chk(d, eb, "R10 bank no clear");
            rd(4'd0, d); chk(d, 1 << ep, "R10 tx after bank");
            rd(4'd1, d); chk(d, (ep == 0) ? 0 : (1 << ep), "R10 rx after bank");
            rd(4'd7, d); chk(d, eb & 12, "R10 bank after clear");
        end
        wr(4'd6, 8'd2);
        wr(4'd7, 8'h00);
        rd(4'd3, d); chk(d, 8'h3B, "R10 bank write clears one");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule